// File: doc/BRIEF.md
# SPI Register Test Target

This block is a small SPI slave that behaves as a known, fixed endpoint against which an SPI master driver can be checked. A driver selects the slave, sends an 8-bit address word, and then moves one 8-bit data word. The level of a separate direction pin at the start of that data word decides whether the word is a read or a write. Every register here is read-only. A driver uses them to discover the peripheral's version and the fastest serial clock it accepts.

The serial pins are sampled with a much faster system clock. SCLK, slave select, MOSI and the direction pin each pass through a two-stage synchroniser, and the serial clock edges are found by comparing successive synchronised samples. The clock polarity and phase are not programmed over the bus. They are taken from two mode pins while the active-low reset is held, and they are frozen at the moment reset is released.

Top module: `spi_probe_slave`

## Requirements
- R1: The mode is captured while `rst_n` is low and is held from its release until the next reset: `mode_i[1]` is the idle SCLK level (CPOL) and `mode_i[0]` is the phase (CPHA). Changes on `mode_i` after release have no effect.
- R2: One register cycle is one address word followed by one data word. Each word is 8 bits and is shifted most significant bit first on both MOSI and MISO.
- R3: `rw_i` is sampled when a data word begins. A value of 1 makes the word a read, which returns the register contents on MISO. A value of 0 makes it a write, and MISO then carries 0x00.
- R4: Address 0x00 returns the version byte 0x01. The major BCD digit is in bits 7:4 and the minor digit in bits 3:0. The version is valid straight after reset.
- R5: Address 0x01 returns bits 15:8 and address 0x02 returns bits 7:0 of the parameter `MAX_SCLK_KHZ`, which is 12500 (0x30D4) by default.
- R6: Reads from any address above 0x02 return 0x00. Writes to any address change nothing that a later read returns.
- R7: Raising `ss_n_i` in the middle of a word abandons the cycle. The next selection starts with an address word.
- R8: `miso_o` is low whenever the slave is not selected, including right after reset.
- R9: MISO carries 0x00 throughout every address word and every write data word.
- R10: With CPHA=0 the slave samples MOSI on the leading SCLK edge and updates MISO on the trailing edge, so the first bit of a word is valid before that word's first edge. With CPHA=1 the slave updates MISO on the leading edge and samples MOSI on the trailing edge.
- R11: Several register cycles may follow each other within one selection, and each cycle samples `rw_i` again for its own data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCLK rate |
| rst_n | input | 1 | Active-low reset; the mode is taken while it is low |
| mode_i | input | 2 | Bit 1 = clock polarity, bit 0 = clock phase |
| rw_i | input | 1 | Direction of the data word: 1 = read, 0 = write |
| sclk_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |

## Verification
Two functions can fall in the same system clock cycle: abandoning a cycle when the slave is deselected, and completing a word on its last sampling edge. The synchroniser delays SCLK and select by the same amount, so the bench provokes the overlap by raising `ss_n_i` at the very instant it drives the eighth sampling edge of an address word. This is done in all four modes. The outcome is judged at the ports: the next selection must decode a fresh address word and return the correct register byte. The same sweep checks the version and rate bytes under every mode, with the mode pins inverted after reset.

// File: rtl/spi_probe_pkg.sv
package spi_probe_pkg;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // Read value of the discovery register file at a given address.
  function automatic logic [7:0] probe_reg_value(
    input logic [7:0]  addr,
    input logic [7:0]  version,
    input logic [15:0] rate_khz
  );
    logic [7:0] v;
    case (addr)
      8'h00:   v = version;
      8'h01:   v = rate_khz[15:8];
      8'h02:   v = rate_khz[7:0];
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/spi_probe_sync.sv
module spi_probe_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/spi_probe_regs.sv
module spi_probe_regs #(
  parameter logic [7:0]  VERSION_BCD  = 8'h01,
  parameter logic [15:0] MAX_SCLK_KHZ = 16'd12500
) (
  input  logic [7:0] addr_i,
  output logic [7:0] rdata_o
);
  import spi_probe_pkg::*;

  assign rdata_o = probe_reg_value(addr_i, VERSION_BCD, MAX_SCLK_KHZ);
endmodule

// File: rtl/spi_probe_engine.sv
module spi_probe_engine #(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              sclk_s,
  input  logic              ss_n_s,
  input  logic              mosi_s,
  input  logic              rw_s,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [WORD_W-1:0] addr_o,
  output logic              miso_o,
  output logic              sel_o,
  output logic              sample_evt_o,
  output logic              shift_evt_o,
  output logic              in_data_o,
  output logic              rw_q_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  import spi_probe_pkg::*;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic              sclk_d;
  logic              rise, fall, lead, trail, sel;
  logic              sample_evt, shift_evt;
  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_sr, tx_sr, addr_q, load_val;
  logic              rw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise  = sclk_s & ~sclk_d;
  assign fall  = ~sclk_s & sclk_d;
  assign lead  = cpol_i ? fall : rise;
  assign trail = cpol_i ? rise : fall;
  assign sel   = ~ss_n_s;

  // Sampling edge and output edge swap roles with the phase setting.
  assign sample_evt = sel & (cpha_i ? trail : lead);
  assign shift_evt  = sel & (cpha_i ? lead : trail);

  assign load_val = (phase == PH_DATA && rw_s) ? rd_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
    end else if (!sel) begin
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rw_q    <= 1'b0;
    end else begin
      if (sample_evt) begin
        rx_sr   <= {rx_sr[WORD_W-2:0], mosi_s};
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          if (phase == PH_ADDR) begin
            addr_q <= {rx_sr[WORD_W-2:0], mosi_s};
            phase  <= PH_DATA;
          end else begin
            phase  <= PH_ADDR;
          end
        end
      end
      if (shift_evt) begin
        if (bit_cnt == '0) begin
          tx_sr <= load_val;
          if (phase == PH_DATA) rw_q <= rw_s;
        end else begin
          tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign addr_o       = addr_q;
  assign miso_o       = sel & tx_sr[WORD_W-1];
  assign sel_o        = sel;
  assign sample_evt_o = sample_evt;
  assign shift_evt_o  = shift_evt;
  assign in_data_o    = (phase == PH_DATA);
  assign rw_q_o       = rw_q;
  assign bit_cnt_o    = bit_cnt;
endmodule

// File: rtl/spi_probe_slave.sv
module spi_probe_slave #(
  parameter logic [7:0]  VERSION_BCD  = 8'h01,
  parameter logic [15:0] MAX_SCLK_KHZ = 16'd12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       rw_i,
  input  logic       sclk_i,
  input  logic       ss_n_i,
  input  logic       mosi_i,
  output logic       miso_o
);
  localparam int WORD_W = 8;
  localparam int CNT_W  = $clog2(WORD_W);

  logic              cpol_q, cpha_q;
  logic [3:0]        sync_q;
  logic              sclk_s, ss_n_s, mosi_s, rw_s;
  logic [WORD_W-1:0] addr, rd_data;
  logic              ss_sel, sample_evt, shift_evt, in_data, rw_q;
  logic [CNT_W-1:0]  bit_cnt;

  // Mode follows the pins while reset is held and freezes at release.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpol_q <= mode_i[1];
      cpha_q <= mode_i[0];
    end
  end

  spi_probe_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({rw_i, ss_n_i, mosi_i, sclk_i}),
    .q_o   (sync_q)
  );
  assign {rw_s, ss_n_s, mosi_s, sclk_s} = sync_q;

  spi_probe_regs #(.VERSION_BCD(VERSION_BCD), .MAX_SCLK_KHZ(MAX_SCLK_KHZ)) u_regs (
    .addr_i  (addr),
    .rdata_o (rd_data)
  );

  spi_probe_engine #(.WORD_W(WORD_W)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpol_i       (cpol_q),
    .cpha_i       (cpha_q),
    .sclk_s       (sclk_s),
    .ss_n_s       (ss_n_s),
    .mosi_s       (mosi_s),
    .rw_s         (rw_s),
    .rd_data_i    (rd_data),
    .addr_o       (addr),
    .miso_o       (miso_o),
    .sel_o        (ss_sel),
    .sample_evt_o (sample_evt),
    .shift_evt_o  (shift_evt),
    .in_data_o    (in_data),
    .rw_q_o       (rw_q),
    .bit_cnt_o    (bit_cnt)
  );
endmodule

// File: rtl/spi_probe_chk.sv
module spi_probe_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ss_n_i,
  input logic             ss_sel,
  input logic             miso_o,
  input logic             cpol,
  input logic             cpha,
  input logic             in_data,
  input logic             rw_q,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sample_evt,
  input logic             shift_evt
);
  // R8: three cycles of raw deselect guarantee a low output
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2)) |-> !miso_o);

  // R1: polarity and phase never move between resets
  p_mode_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable({cpol, cpha}));

  // R7: deselect leaves the protocol waiting for an address word at bit 0
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_sel |=> (bit_cnt == '0 && !in_data));

  // R9: address words shift out zeros once the first bit has been taken
  p_addr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_data && bit_cnt != '0) |-> !miso_o);

  // R9: write data words shift out zeros
  p_write_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !rw_q && bit_cnt != '0) |-> !miso_o);

  // R10: sampling and output updates come from opposite edges
  p_edge_split_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_evt && shift_evt));
endmodule

bind spi_probe_slave spi_probe_chk #(.CNT_W(3)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ss_n_i     (ss_n_i),
  .ss_sel     (ss_sel),
  .miso_o     (miso_o),
  .cpol       (cpol_q),
  .cpha       (cpha_q),
  .in_data    (in_data),
  .rw_q       (rw_q),
  .bit_cnt    (bit_cnt),
  .sample_evt (sample_evt),
  .shift_evt  (shift_evt)
);

// File: tb/spi_probe_slave_bench.sv
module spi_probe_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;
  localparam logic [15:0] RATE = 16'd12500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_pin = 2'b00;
  logic       rw = 1'b0, sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso;
  logic       cpol = 1'b0, cpha = 1'b0;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_probe_slave u_spi_probe_slave (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_pin), .rw_i(rw),
    .sclk_i(sclk), .ss_n_i(ss_n), .mosi_i(mosi), .miso_o(miso)
  );

  function automatic logic [7:0] expect_reg(input logic [7:0] a);
    if (a == 8'h00) return 8'h01;                 // BCD 0.1
    if (a == 8'h01) return 8'((RATE >> 8) & 16'hFF);
    if (a == 8'h02) return 8'(RATE % 256);
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d%0d actual=%02h expected=%02h", req, cpol, cpha, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; ss_n = 1'b1; mode_pin = m; cpol = m[1]; cpha = m[0]; sclk = m[1];
    repeat (5) @(posedge clk);
    #3;
    rst_n = 1'b1;
    mode_pin = ~m;  // R1: later pin values must be ignored
    repeat (4) @(posedge clk);
    #3;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      if (!cpha) begin
        mosi = tx[i]; #HALF; rx[i] = miso; sclk = ~cpol; #HALF; sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = tx[i]; #HALF; rx[i] = miso; sclk = cpol; #HALF;
      end
    end
  endtask

  task automatic select_slave();
    ss_n = 1'b0; #HALF;
  endtask

  task automatic deselect_slave();
    #HALF; ss_n = 1'b1; #(2*HALF);
  endtask

  task automatic reg_cycle(input logic [7:0] a, input logic rd, input logic [7:0] wd,
                           output logic [7:0] echo, output logic [7:0] data);
    rw = rd;
    select_slave();
    xfer(a, echo, 8);
    xfer(wd, data, 8);
    deselect_slave();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [7:0] echo, data, junk;
    logic [7:0] addrs [8] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h7F, 8'h80, 8'hFF};
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      chk("R8 idle after reset", {7'd0, miso}, 8'h00);

      // R4 R5 R6 R2 R10: read sweep in this mode
      for (int k = 0; k < 8; k++) begin
        reg_cycle(addrs[k], 1'b1, 8'hC3, echo, data);
        chk("R9 address word zeros", echo, 8'h00);
        chk("R4/R5/R6 read value", data, expect_reg(addrs[k]));
        chk("R8 idle between cycles", {7'd0, miso}, 8'h00);
      end

      // R6 R3 R9: writes ignored, write data word shifts zeros
      for (int k = 0; k < 4; k++) begin
        reg_cycle(addrs[k], 1'b0, 8'hA5, echo, data);
        chk("R9 write data zeros", data, 8'h00);
        reg_cycle(addrs[k], 1'b1, 8'h00, echo, data);
        chk("R6 read after write", data, expect_reg(addrs[k]));
      end

      // R7: abort inside address word, then inside data word
      rw = 1'b1;
      select_slave(); xfer(8'h01, junk, 4); deselect_slave();
      reg_cycle(8'h02, 1'b1, 8'h00, echo, data);
      chk("R7 abort in address", data, expect_reg(8'h02));
      select_slave(); xfer(8'h01, junk, 8); xfer(8'h00, junk, 3); deselect_slave();
      reg_cycle(8'h00, 1'b1, 8'h00, echo, data);
      chk("R7 abort in data", data, expect_reg(8'h00));

      // R7: deselect arrives with the last sampling edge of the address word
      rw = 1'b1;
      select_slave();
      xfer(8'h01, junk, 7);
      mosi = 1'b1;
      if (!cpha) begin #HALF; sclk = ~cpol; ss_n = 1'b1; #HALF; sclk = cpol; end
      else begin sclk = ~cpol; #HALF; sclk = cpol; ss_n = 1'b1; #HALF; end
      #(2*HALF);
      chk("R8 idle after overlap", {7'd0, miso}, 8'h00);
      reg_cycle(8'h01, 1'b1, 8'h00, echo, data);
      chk("R7 overlap then fresh cycle", data, expect_reg(8'h01));

      // R11 R3: back-to-back cycles in one selection, direction per cycle
      rw = 1'b1;
      select_slave();
      xfer(8'h01, echo, 8); xfer(8'h00, data, 8);
      chk("R11 first cycle read", data, expect_reg(8'h01));
      xfer(8'h02, echo, 8);
      chk("R11 second address zeros", echo, 8'h00);
      xfer(8'h00, data, 8);
      chk("R11 second cycle read", data, expect_reg(8'h02));
      rw = 1'b0;
      xfer(8'h00, echo, 8); xfer(8'h55, data, 8);
      chk("R3 resampled write", data, 8'h00);
      rw = 1'b1;
      xfer(8'h00, echo, 8); xfer(8'h00, data, 8);
      chk("R3 resampled read", data, expect_reg(8'h00));
      deselect_slave();
      chk("R8 idle at end", {7'd0, miso}, 8'h00);
    end
    done = 1'b1;
    report();
  end
endmodule